// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the data-processing unit of a 32-bit load/store processor pipeline. Each cycle it takes a first operand, a second operand that an upstream shifter or immediate rotator has already prepared, and the carry that stage produced. It also takes a flag telling whether that stage actually moved any bits, a 4-bit operation code, a set-flags request, and the current four condition flags. From these it computes one of sixteen logical or arithmetic results. It also decides whether the destination register should be written and produces the next flag values.

Subtraction treats carry as the inverse of borrow. Two reverse-subtract forms swap the operand order. Four test/compare codes only update flags. Logical operations draw their carry from the shifter rather than from the adder. A separate count-leading-zeros mode bypasses the opcode. By default the outputs are registered, giving a one-cycle latency. Setting `REG_OUT` to 0 makes the block purely combinational.

Top module: `dp_alu_core`

## Requirements
- R1: The opcode selects the operation: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST (AND), 9 TEQ (EOR), 10 CMP (SUB), 11 CMN (ADD), 12 ORR, 13 MOV (second operand), 14 BIC (first AND NOT second), 15 MVN (NOT second).
- R2: ADC adds the incoming C flag (flags_in bit 1) to the sum. SBC computes first minus second minus (1 − C).
- R3: RSB computes second minus first. RSC computes second minus first minus (1 − C).
- R4: For opcodes 8 to 11, wr_en is 0 and the flags are updated even when set_flags is 0. The result port still carries the computed value.
- R5: For the add forms, C is the unsigned carry-out of bit 31. For the subtract forms, C is 1 exactly when no borrow occurs.
- R6: For the add and subtract forms, V (bit 0) is set on two's-complement signed overflow.
- R7: For logical opcodes (0, 1, 8, 9, 12 to 15), C takes shift_carry when shift_active is 1 and otherwise keeps its previous value. V always keeps its previous value.
- R8: When the flags update, N (bit 3) is bit 31 of the result and Z (bit 2) is 1 exactly when the 32-bit result is zero.
- R9: When set_flags is 0 and the opcode is not 8 to 11, flags_out equals flags_in.
- R10: With clz_mode at 1, result is the count of leading zero bits of op_b (32 when op_b is zero), wr_en is 1, and flags_out equals flags_in.
- R11: With REG_OUT=1, outputs appear one clock after their inputs. While rst_n is low, result, wr_en and flags_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted or rotated |
| shift_carry | input | 1 | Carry out of the shifter or rotator |
| shift_active | input | 1 | High when the shifter moved bits |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request flag update |
| clz_mode | input | 1 | Count-leading-zeros of op_b instead of opcode |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench covers the cases where operand order and carry polarity matter:
- A subtract that borrows must clear C, and a subtract of equal values must set both C and Z. A design that took C from the raw adder borrow would invert both cases.
- The reverse forms must swap operands. A swapped-operand bug yields the negated value.
- ADC, SBC and RSC are driven with C both set and clear. A missing carry term is then off by one.
- Logical operations with and without shifter activity catch a design that takes C from the adder or clobbers V.
- Compare codes with set_flags low must still move the flags while keeping wr_en low.
- CLZ is checked at zero, at the top bit and at interior positions.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // Opcodes that only update flags
  function automatic logic op_is_test(input logic [3:0] op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  // Opcodes that go through the adder
  function automatic logic op_is_arith(input logic [3:0] op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         ovf
);

  logic [W-1:0] x, y;
  logic         cin;
  logic         swap, negate;

  always_comb begin
    swap   = (op == OP_RSB) || (op == OP_RSC);
    negate = (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
             (op == OP_RSC) || (op == OP_CMP);
    case (op)
      OP_SUB, OP_RSB, OP_CMP:  cin = 1'b1;
      OP_ADC, OP_SBC, OP_RSC:  cin = c_in;
      default:                 cin = 1'b0;
    endcase
    x = swap ? b : a;
    y = swap ? a : b;
    if (negate) y = ~y;
  end

  // Carry out of the top bit; for negated forms it reads as "no borrow"
  function automatic logic [W:0] add_full(input logic [W-1:0] p,
                                          input logic [W-1:0] q,
                                          input logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  // Signed overflow: same-signed inputs with a differently signed sum
  function automatic logic add_ovf(input logic [W-1:0] p,
                                   input logic [W-1:0] q,
                                   input logic [W-1:0] s);
    return (p[W-1] == q[W-1]) && (s[W-1] != p[W-1]);
  endfunction

  always_comb begin
    {c_out, sum} = add_full(x, y, cin);
    ovf          = add_ovf(x, y, sum);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end

endmodule

// File: rtl/alu_clz.sv
module alu_clz #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] count
);

  // Scan from the top; the first set bit stops the count
  function automatic logic [CW-1:0] lead_zeros(input logic [W-1:0] d);
    logic [CW-1:0] n;
    logic          hit;
    n   = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (d[i]) hit = 1'b1;
      if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  assign count = lead_zeros(v);

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_carry,
  input  logic         shift_active,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic         clz_mode,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags_out
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sum, log_res, core_res, res_nxt;
  logic          add_c, add_v;
  logic [CW-1:0] clz_cnt;
  logic          is_test, is_arith, flag_upd, wr_nxt;
  logic          c_new, v_new;
  logic [3:0]    flags_nxt;

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .op(opcode), .c_in(flags_in[FLAG_C]),
    .sum(sum), .c_out(add_c), .ovf(add_v)
  );

  alu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .op(opcode), .y(log_res)
  );

  alu_clz #(.W(W)) u_clz (
    .v(op_b), .count(clz_cnt)
  );

  always_comb begin
    is_test  = op_is_test(opcode);
    is_arith = op_is_arith(opcode);
    flag_upd = !clz_mode && (set_flags || is_test);
    core_res = is_arith ? sum : log_res;
    res_nxt  = clz_mode ? {{(W-CW){1'b0}}, clz_cnt} : core_res;
    wr_nxt   = clz_mode || !is_test;
    c_new    = is_arith ? add_c : (shift_active ? shift_carry : flags_in[FLAG_C]);
    v_new    = is_arith ? add_v : flags_in[FLAG_V];
    flags_nxt = flag_upd ? {core_res[W-1], (core_res == '0), c_new, v_new} : flags_in;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic past_ok;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          result    <= '0;
          wr_en     <= 1'b0;
          flags_out <= '0;
          past_ok   <= 1'b0;
        end else begin
          result    <= res_nxt;
          wr_en     <= wr_nxt;
          flags_out <= flags_nxt;
          past_ok   <= 1'b1;
        end
      end

      // R11: outputs follow the computed values one clock later
      p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (result == $past(res_nxt)) && (flags_out == $past(flags_nxt))
                    && (wr_en == $past(wr_nxt)));
    end else begin : g_comb
      assign result    = res_nxt;
      assign wr_en     = wr_nxt;
      assign flags_out = flags_nxt;
    end
  endgenerate

  // R4: test codes never request a register write
  p_test_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clz_mode && opcode[3:2] == 2'b10) |-> !wr_nxt);

  // R9: flags pass through when no update is requested
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clz_mode && !set_flags && opcode[3:2] != 2'b10) |-> (flags_nxt == flags_in));

  // R7: logical operations leave V alone
  p_logic_keeps_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clz_mode && !op_is_arith(opcode)) |-> (flags_nxt[FLAG_V] == flags_in[FLAG_V]));

  // R8: Z agrees with the result whenever the flags move
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clz_mode && (set_flags || opcode[3:2] == 2'b10)) |->
      (flags_nxt[FLAG_Z] == (res_nxt == '0)) && (flags_nxt[FLAG_N] == res_nxt[W-1]));

  // R10: count stays within 0..W and leaves the flags untouched
  p_clz_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clz_mode |-> (res_nxt <= W) && (flags_nxt == flags_in) && wr_nxt);

endmodule

// File: tb/dp_alu_core_bench.sv
`timescale 1ns/1ps
module dp_alu_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        shift_carry = 1'b0, shift_active = 1'b0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0, clz_mode = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  dp_alu_core u_dp_alu_core (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .shift_carry(shift_carry), .shift_active(shift_active),
    .opcode(opcode), .set_flags(set_flags), .clz_mode(clz_mode),
    .flags_in(flags_in), .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic        sa;
    logic        s;
    logic [3:0]  fin;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fout;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  // flags are {N,Z,C,V}
  localparam vec_t VT [NV] = '{
    '{4'h0, 32'hF0F0_00FF, 32'hFF00_0F0F, 1'b1, 1'b1, 1'b1, 4'b0000, 32'hF000_000F, 1'b1, 4'b1010, 8'd1},  // R1 AND
    '{4'h1, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, 1'b1, 4'b0011, 32'h0000_0000, 1'b1, 4'b0101, 8'd8},  // R8 EOR zero
    '{4'h2, 32'd5,         32'd3,         1'b0, 1'b0, 1'b1, 4'b0000, 32'd2,         1'b1, 4'b0010, 8'd5},  // R5 no borrow
    '{4'h2, 32'd3,         32'd5,         1'b0, 1'b0, 1'b1, 4'b0000, 32'hFFFF_FFFE, 1'b1, 4'b1000, 8'd5},  // R5 borrow
    '{4'h2, 32'h8000_0000, 32'd1,         1'b0, 1'b0, 1'b1, 4'b0000, 32'h7FFF_FFFF, 1'b1, 4'b0011, 8'd6},  // R6 sub ovf
    '{4'h3, 32'd3,         32'd10,        1'b0, 1'b0, 1'b1, 4'b0000, 32'd7,         1'b1, 4'b0010, 8'd3},  // R3 RSB
    '{4'h4, 32'hFFFF_FFFF, 32'd1,         1'b0, 1'b0, 1'b1, 4'b0000, 32'd0,         1'b1, 4'b0110, 8'd5},  // R5 add carry
    '{4'h4, 32'h7FFF_FFFF, 32'd1,         1'b0, 1'b0, 1'b1, 4'b0000, 32'h8000_0000, 1'b1, 4'b1001, 8'd6},  // R6 add ovf
    '{4'h5, 32'd10,        32'd20,        1'b0, 1'b0, 1'b0, 4'b0010, 32'd31,        1'b1, 4'b0010, 8'd2},  // R2 ADC, R9 hold
    '{4'h6, 32'd10,        32'd3,         1'b0, 1'b0, 1'b1, 4'b0000, 32'd6,         1'b1, 4'b0010, 8'd2},  // R2 SBC C=0
    '{4'h7, 32'd3,         32'd10,        1'b0, 1'b0, 1'b1, 4'b0010, 32'd7,         1'b1, 4'b0010, 8'd3},  // R3 RSC C=1
    '{4'h8, 32'h0000_00F0, 32'h0000_000F, 1'b1, 1'b1, 1'b0, 4'b0001, 32'd0,         1'b0, 4'b0111, 8'd4},  // R4 TST
    '{4'h9, 32'h8000_0000, 32'd0,         1'b0, 1'b0, 1'b0, 4'b0010, 32'h8000_0000, 1'b0, 4'b1010, 8'd7},  // R7 TEQ keeps C
    '{4'hA, 32'd7,         32'd7,         1'b0, 1'b0, 1'b0, 4'b1000, 32'd0,         1'b0, 4'b0110, 8'd4},  // R4 CMP
    '{4'hB, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'b0000, 32'd0,         1'b0, 4'b0111, 8'd6},  // R6 CMN ovf
    '{4'hC, 32'h0000_0F00, 32'h0000_00F0, 1'b1, 1'b0, 1'b1, 4'b0100, 32'h0000_0FF0, 1'b1, 4'b0000, 8'd7},  // R7 ORR no shift
    '{4'hD, 32'h0000_DEAD, 32'h8000_0001, 1'b1, 1'b1, 1'b1, 4'b0000, 32'h8000_0001, 1'b1, 4'b1010, 8'd1},  // R1 MOV
    '{4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b1, 1'b1, 4'b0011, 32'hFFFF_0000, 1'b1, 4'b1001, 8'd1},  // R1 BIC
    '{4'hF, 32'd0,         32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'b1111, 32'd0,         1'b1, 4'b1111, 8'd9},  // R9 MVN hold
    '{4'h2, 32'h42,        32'h42,        1'b0, 1'b0, 1'b1, 4'b0000, 32'd0,         1'b1, 4'b0110, 8'd5}   // R5 equal
  };

  task automatic check(input string tag, input logic [31:0] er, input logic ew,
                       input logic [3:0] ef);
    n_checks++;
    if (result !== er || wr_en !== ew || flags_out !== ef) begin
      n_fail++;
      $display("FAIL %s: got res=%h wr=%b flags=%b, expected res=%h wr=%b flags=%b",
               tag, result, wr_en, flags_out, er, ew, ef);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic sa, input logic s,
                       input logic cz, input logic [3:0] fin);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = sc; shift_active = sa;
    set_flags = s; clz_mode = cz; flags_in = fin;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // R11: reset state with non-trivial inputs
    drive(4'h4, 32'd1, 32'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'b1111);
    @(negedge clk);
    check("R11 reset", 32'd0, 1'b0, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].op, VT[i].a, VT[i].b, VT[i].sc, VT[i].sa, VT[i].s, 1'b0, VT[i].fin);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].res, VT[i].wr, VT[i].fout);
    end

    // R10: leading-zero count corners
    drive(4'h4, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1010);
    @(negedge clk);
    check("R10 zero", 32'd32, 1'b1, 4'b1010);
    drive(4'h2, 32'd0, 32'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0101);
    @(negedge clk);
    check("R10 one", 32'd31, 1'b1, 4'b0101);
    drive(4'h0, 32'd0, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000);
    @(negedge clk);
    check("R10 top", 32'd0, 1'b1, 4'b0000);
    drive(4'hA, 32'd0, 32'h0001_0F00, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0011);
    @(negedge clk);
    check("R10 mid", 32'd15, 1'b1, 4'b0011);

    // R11: one-cycle latency - just before the next edge the old value remains
    drive(4'hD, 32'd0, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    check("R11 load", 32'h0000_1234, 1'b1, 4'b0000);
    drive(4'hD, 32'd0, 32'h0000_5678, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
    #2;
    check("R11 latency", 32'h0000_1234, 1'b1, 4'b0000);
    @(negedge clk);
    check("R11 update", 32'h0000_5678, 1'b1, 4'b0000);

    // R2: ADC with C clear adds nothing extra; R3: RSC with C clear
    drive(4'h5, 32'd10, 32'd20, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000);
    @(negedge clk);
    check("R2 adc c0", 32'd30, 1'b1, 4'b0000);
    drive(4'h7, 32'd3, 32'd10, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000);
    @(negedge clk);
    check("R3 rsc c0", 32'd6, 1'b1, 4'b0010);

    finish_run();
  end

endmodule